// File: doc/BRIEF.md
# Single-Wire Bus Device Reset, Presence and Bit-Slot Responder

This block is the device-side front end of a single open-drain data wire. It samples the wire through a synchroniser and measures every low period. A low period that is long enough counts as a bus reset. The block then answers with a timed presence pulse. Once presence is done, each host falling edge opens a bit slot. The block samples the wire at a fixed point in that slot and hands the written bit to the logic above it. If that logic asks for a zero, the block also holds the wire low for the first part of the slot, which is how a read slot returns a 0. A speed-select input chooses standard or overdrive timing. All timings are counted in clock cycles derived from a clocks-per-microsecond parameter.

The control is one state machine with seven states:
- ST_IDLE waits for a slot to start.
- ST_GUARD is the recovery hold-off after the wire rises.
- ST_SLOT times the sample point and drives a requested zero.
- ST_SLOT_END waits for the wire to go high again.
- ST_RST_LOW waits for the end of a reset pulse.
- ST_PD_WAIT is the gap before presence.
- ST_PD_LOW drives the presence pulse.

The transitions are:
- IDLE→SLOT on a synchronised low.
- SLOT→SLOT_END at the sample point.
- SLOT_END→GUARD when the wire goes high, or SLOT_END→IDLE at overdrive.
- GUARD→IDLE after the hold-off time of continuous high.
- RST_LOW→PD_WAIT when the wire goes high.
- PD_WAIT→PD_LOW when the gap expires.
- PD_LOW→GUARD when the pulse expires.
- Any state except RST_LOW goes to RST_LOW when the reset length is reached.

Top module: `owire_slave_front`

## Requirements
- R1: While rst_n is low, and on release of reset, line_pull, bus_reset and bit_valid are 0.
- R2: A run of synchronised low samples of 480 cycles (standard) or 48 cycles (overdrive) gives exactly one one-cycle bus_reset pulse. Shorter runs of 470 (standard) or 40 (overdrive) give none.
- R3: After the host releases the wire at the end of a reset, line_pull rises 33 cycles later at standard speed and 5 cycles later at overdrive. That is the 30 or 2 cycle gap plus 3 cycles of synchroniser and state latency, within 15–60 and 2–6 respectively.
- R4: The presence pulse holds line_pull high for exactly 120 cycles (standard) or 16 cycles (overdrive).
- R5: Every recognised slot gives one one-cycle bit_valid. bit_value is 1 after a host low of 8 cycles (standard) or 1 cycle (overdrive). It is 0 after a host low of 80 or 8 cycles.
- R6: If tx_zero is 1 when a slot starts, line_pull is held high from 3 cycles after the host's falling edge, for 30 cycles (standard) or 3 cycles (overdrive). The wire reads low mid-slot and the reported bit is 0.
- R7: If tx_zero is 0 when a slot starts, line_pull stays 0 through the slot. After a short host pulse the wire is high mid-slot and the reported bit is 1.
- R8: At standard speed, a new low that follows a single high cycle after a slot is ignored and reports no bit. At overdrive, the same pattern is decoded as a second slot.
- R9: A reset that starts during a slot, or during the gap before presence, aborts that activity, pulses bus_reset and produces a fresh presence pulse.
- R10: The outputs follow a two-stage synchroniser on line_in, cycle for cycle, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Wire level as seen at the pad (1 = high) |
| overdrive | input | 1 | 1 selects overdrive timing, 0 selects standard |
| tx_zero | input | 1 | Upper logic asks for a 0 on the next slot |
| line_pull | output | 1 | 1 pulls the wire low through the open-drain driver |
| bus_reset | output | 1 | One-cycle pulse when a reset has been detected |
| bit_valid | output | 1 | One-cycle pulse when a slot bit has been sampled |
| bit_value | output | 1 | Sampled bit, valid with bit_valid |

## Verification
The patterns come in groups, and each one tells a specific pair of behaviours apart:
- Long and short host lows at both speeds separate reset from write-zero.
- Short and long slot pulses separate written ones from zeros.
- Read slots with and without a zero request show whether the block drives the wire.
- A one-cycle high gap after a slot separates the standard-speed hold-off from the overdrive case, where there is none.
- Resets that start mid-slot and mid-gap show that abort and restart take priority.

A behavioural reference model, fed the same wired-AND line, is compared with the outputs every cycle.

// File: rtl/ow_resp_pkg.sv
package ow_resp_pkg;
    localparam int TW = 16;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_GUARD    = 3'd1,
        ST_SLOT     = 3'd2,
        ST_SLOT_END = 3'd3,
        ST_RST_LOW  = 3'd4,
        ST_PD_WAIT  = 3'd5,
        ST_PD_LOW   = 3'd6
    } ow_state_e;

    typedef struct packed {
        logic [TW-1:0] rst_len;
        logic [TW-1:0] pd_gap;
        logic [TW-1:0] pd_len;
        logic [TW-1:0] smp_at;
        logic [TW-1:0] guard;
    } ow_times_t;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_timing.sv
module ow_timing
    import ow_resp_pkg::*;
#(
    parameter int CLK_PER_US = 1,
    parameter int STD_RST_US = 480,
    parameter int STD_GAP_US = 30,
    parameter int STD_PD_US  = 120,
    parameter int STD_SMP_US = 30,
    parameter int STD_GRD_US = 2,
    parameter int OD_RST_US  = 48,
    parameter int OD_GAP_US  = 2,
    parameter int OD_PD_US   = 16,
    parameter int OD_SMP_US  = 3,
    parameter int OD_GRD_US  = 0
) (
    input  logic      overdrive,
    output ow_times_t times
);
    localparam ow_times_t T_STD = '{
        rst_len: TW'(STD_RST_US * CLK_PER_US),
        pd_gap:  TW'(STD_GAP_US * CLK_PER_US),
        pd_len:  TW'(STD_PD_US  * CLK_PER_US),
        smp_at:  TW'(STD_SMP_US * CLK_PER_US),
        guard:   TW'(STD_GRD_US * CLK_PER_US)
    };
    localparam ow_times_t T_OD = '{
        rst_len: TW'(OD_RST_US * CLK_PER_US),
        pd_gap:  TW'(OD_GAP_US * CLK_PER_US),
        pd_len:  TW'(OD_PD_US  * CLK_PER_US),
        smp_at:  TW'(OD_SMP_US * CLK_PER_US),
        guard:   TW'(OD_GRD_US * CLK_PER_US)
    };

    assign times = overdrive ? T_OD : T_STD;
endmodule

// File: rtl/ow_lowmeter.sv
module ow_lowmeter
    import ow_resp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_s,
    input  logic [TW-1:0] rst_len,
    output logic          rst_hit
);
    logic [TW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 low_run <= '0;
        else if (line_s)            low_run <= '0;
        else if (low_run != '1)     low_run <= low_run + TW'(1);
    end

    assign rst_hit = !line_s && (low_run == rst_len - TW'(1));

    p_hit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> !rst_hit);
endmodule

// File: rtl/owire_slave_front.sv
module owire_slave_front
    import ow_resp_pkg::*;
#(
    parameter int CLK_PER_US  = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic overdrive,
    input  logic tx_zero,
    output logic line_pull,
    output logic bus_reset,
    output logic bit_valid,
    output logic bit_value
);
    ow_times_t     times;
    logic          line_s;
    logic          rst_hit;
    ow_state_e     state, nstate;
    logic [TW-1:0] cnt, ncnt;
    logic          drv, ndrv;
    logic          nbv, nbval, nbr;

    ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );

    ow_timing #(.CLK_PER_US(CLK_PER_US)) u_timing (
        .overdrive(overdrive), .times(times)
    );

    ow_lowmeter u_low (
        .clk(clk), .rst_n(rst_n), .line_s(line_s),
        .rst_len(times.rst_len), .rst_hit(rst_hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            drv       <= 1'b0;
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
            bus_reset <= 1'b0;
        end else begin
            state     <= nstate;
            cnt       <= ncnt;
            drv       <= ndrv;
            bit_valid <= nbv;
            bit_value <= nbval;
            bus_reset <= nbr;
        end
    end

    // Next-state logic; reset detection outranks every state but RST_LOW
    always_comb begin
        nstate = state;
        ncnt   = cnt;
        ndrv   = drv;
        nbv    = 1'b0;
        nbval  = bit_value;
        nbr    = 1'b0;
        if (rst_hit && state != ST_RST_LOW) begin
            nstate = ST_RST_LOW;
            ncnt   = '0;
            ndrv   = 1'b0;
            nbr    = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!line_s) begin
                        nstate = ST_SLOT;
                        ncnt   = '0;
                        ndrv   = tx_zero;
                    end
                end
                ST_GUARD: begin
                    if (!line_s) begin
                        ncnt = '0;
                    end else if (cnt + TW'(1) >= times.guard) begin
                        nstate = ST_IDLE;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + TW'(1);
                    end
                end
                ST_SLOT: begin
                    if (cnt == times.smp_at - TW'(1)) begin
                        nbv    = 1'b1;
                        nbval  = line_s;
                        nstate = ST_SLOT_END;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + TW'(1);
                    end
                end
                ST_SLOT_END: begin
                    if (line_s) begin
                        nstate = (times.guard == '0) ? ST_IDLE : ST_GUARD;
                        ncnt   = '0;
                        ndrv   = 1'b0;
                    end
                end
                ST_RST_LOW: begin
                    if (line_s) begin
                        nstate = ST_PD_WAIT;
                        ncnt   = '0;
                    end
                end
                ST_PD_WAIT: begin
                    if (cnt == times.pd_gap - TW'(1)) begin
                        nstate = ST_PD_LOW;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + TW'(1);
                    end
                end
                ST_PD_LOW: begin
                    if (cnt == times.pd_len - TW'(1)) begin
                        nstate = ST_GUARD;
                        ncnt   = '0;
                    end else begin
                        ncnt = cnt + TW'(1);
                    end
                end
                default: begin
                    nstate = ST_IDLE;
                    ncnt   = '0;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        line_pull = (state == ST_PD_LOW) || (state == ST_SLOT && drv);
    end

    p_reset_from_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !$past(line_s));
    p_reset_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);
    p_bit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);
    p_release_on_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> !line_pull);
    p_drive_on_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_pull) && state == ST_SLOT) |-> $past(tx_zero));
    p_zero_when_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && $past(drv)) |-> !bit_value);
endmodule

// File: tb/test_owire_slave_front.sv
module test_owire_slave_front;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_pull = 1'b0;
    logic overdrive = 1'b0;
    logic tx_zero = 1'b0;
    logic line_in;
    logic line_pull, bus_reset, bit_valid, bit_value;

    int nchk = 0;
    int nerr = 0;
    int nrst = 0;
    bit done = 1'b0;
    bit bits_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = ~(host_pull | line_pull);

    owire_slave_front i_owire_slave_front (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .overdrive(overdrive),
        .tx_zero(tx_zero), .line_pull(line_pull), .bus_reset(bus_reset),
        .bit_valid(bit_valid), .bit_value(bit_value)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: states 0 idle,1 guard,2 slot,3 slot end,
    // 4 reset low,5 presence gap,6 presence low
    bit m_s1, m_s2, m_drv, m_bv, m_bval, m_br;
    int m_low, m_st, m_cnt;

    always @(posedge clk or negedge rst_n) begin
        int rt, pw, pl, sm, gd, nst, ncnt;
        bit s, hit, ndrv, nbv, nbval, nbr, pull_now, ln;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_low = 0; m_st = 0; m_cnt = 0;
            m_drv = 0; m_bv = 0; m_bval = 0; m_br = 0;
        end else begin
            rt = overdrive ? 48 : 480;
            pw = overdrive ? 2 : 30;
            pl = overdrive ? 16 : 120;
            sm = overdrive ? 3 : 30;
            gd = overdrive ? 0 : 2;
            pull_now = (m_st == 6) || (m_st == 2 && m_drv);
            ln = !(host_pull || pull_now);
            s = m_s2;
            hit = !s && (m_low == rt - 1);
            nst = m_st; ncnt = m_cnt; ndrv = m_drv; nbv = 0; nbval = m_bval; nbr = 0;
            if (hit && m_st != 4) begin
                nst = 4; ncnt = 0; ndrv = 0; nbr = 1;
            end else begin
                case (m_st)
                    0: if (!s) begin nst = 2; ncnt = 0; ndrv = tx_zero; end
                    1: if (!s) ncnt = 0;
                       else if (m_cnt + 1 >= gd) begin nst = 0; ncnt = 0; end
                       else ncnt = m_cnt + 1;
                    2: if (m_cnt == sm - 1) begin nbv = 1; nbval = s; nst = 3; ncnt = 0; end
                       else ncnt = m_cnt + 1;
                    3: if (s) begin nst = (gd == 0) ? 0 : 1; ncnt = 0; ndrv = 0; end
                    4: if (s) begin nst = 5; ncnt = 0; end
                    5: if (m_cnt == pw - 1) begin nst = 6; ncnt = 0; end
                       else ncnt = m_cnt + 1;
                    6: if (m_cnt == pl - 1) begin nst = 1; ncnt = 0; end
                       else ncnt = m_cnt + 1;
                    default: nst = 0;
                endcase
            end
            m_low = s ? 0 : m_low + 1;
            m_s2 = m_s1; m_s1 = ln;
            m_st = nst; m_cnt = ncnt; m_drv = ndrv; m_bv = nbv; m_bval = nbval; m_br = nbr;
        end
    end

    // Per-cycle comparison and event capture (R10)
    always @(negedge clk) begin
        bit ep;
        if (rst_n && !done) begin
            ep = (m_st == 6) || (m_st == 2 && m_drv);
            chk(line_pull == ep && bit_valid == m_bv && bus_reset == m_br &&
                (!m_bv || bit_value == m_bval), "R10 model line_pull",
                int'(line_pull), int'(ep));
            if (bus_reset) nrst++;
            if (bit_valid) bits_q.push_back(bit_value);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_low(input int n);
        @(negedge clk) host_pull = 1'b1;
        repeat (n) @(negedge clk);
        host_pull = 1'b0;
    endtask

    task automatic reset_seq(input int len, input int exp_gap, input int exp_w,
                             input int gmin, input int gmax, input int wmin, input int wmax);
        int d, w, n0;
        n0 = nrst;
        host_low(len);
        d = 0;
        while (!line_pull && d < 2000) begin @(negedge clk); d++; end
        w = 0;
        while (line_pull && w < 2000) begin @(negedge clk); w++; end
        chk(nrst == n0 + 1, "R2 reset pulse count", nrst - n0, 1);
        chk(d == exp_gap && d >= gmin && d <= gmax, "R3 presence gap", d, exp_gap);
        chk(w == exp_w && w >= wmin && w <= wmax, "R4 presence width", w, exp_w);
        idle(20);
        bits_q.delete();
    endtask

    task automatic write_bit(input bit b, input int low, input int rec, input string req);
        host_low(low);
        idle(rec);
        chk(bits_q.size() == 1, {req, " one bit per slot"}, bits_q.size(), 1);
        if (bits_q.size() > 0) chk(bits_q[0] == b, {req, " bit value"}, int'(bits_q[0]), int'(b));
        bits_q.delete();
    endtask

    task automatic read_bit(input bit txz, input int low, input int probe, input int rec,
                            input string req);
        tx_zero = txz;
        host_low(low);
        idle(probe);
        chk(line_in == !txz, {req, " line mid-slot"}, int'(line_in), int'(!txz));
        tx_zero = 1'b0;
        idle(rec);
        chk(bits_q.size() == 1 && bits_q[0] == !txz, {req, " read bit"},
            bits_q.size() > 0 ? int'(bits_q[0]) : -1, int'(!txz));
        bits_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n0;
        idle(5);
        chk(line_pull == 0 && bus_reset == 0 && bit_valid == 0, "R1 in reset",
            int'(line_pull | bus_reset | bit_valid), 0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        chk(line_pull == 0 && bus_reset == 0 && bit_valid == 0, "R1 after reset",
            int'(line_pull | bus_reset | bit_valid), 0);
        idle(10);

        // Standard speed
        reset_seq(500, 33, 120, 15, 60, 60, 240);
        write_bit(1'b1, 8, 40, "R5 std one");
        write_bit(1'b0, 80, 40, "R5 std zero");
        write_bit(1'b1, 8, 40, "R5 std one b");
        write_bit(1'b0, 80, 40, "R5 std zero b");
        read_bit(1'b1, 6, 9, 40, "R6 std");
        read_bit(1'b0, 6, 9, 40, "R7 std");

        n0 = nrst;
        host_low(470); idle(40);
        chk(nrst == n0, "R2 std short low no reset", nrst - n0, 0);
        bits_q.delete();

        // Hold-off: one-cycle high gap after a slot
        host_low(80);
        host_low(10);
        idle(40);
        chk(bits_q.size() == 1, "R8 std gap ignored", bits_q.size(), 1);
        bits_q.delete();

        // Reset during a slot with a zero request
        tx_zero = 1'b1;
        n0 = nrst;
        reset_seq(500, 33, 120, 15, 60, 60, 240);
        tx_zero = 1'b0;
        chk(nrst == n0 + 1, "R9 abort slot", nrst - n0, 1);

        // Reset during presence gap
        n0 = nrst;
        host_low(500);
        idle(10);
        chk(line_pull == 0, "R9 still in gap", int'(line_pull), 0);
        reset_seq(500, 33, 120, 15, 60, 60, 240);
        chk(nrst == n0 + 2, "R9 abort gap", nrst - n0, 2);

        // Overdrive
        @(negedge clk) overdrive = 1'b1;
        idle(20);
        reset_seq(60, 5, 16, 2, 6, 8, 24);
        write_bit(1'b1, 1, 10, "R5 od one");
        write_bit(1'b0, 8, 10, "R5 od zero");
        write_bit(1'b0, 8, 10, "R5 od zero b");
        write_bit(1'b1, 1, 10, "R5 od one b");
        read_bit(1'b1, 1, 3, 10, "R6 od");
        read_bit(1'b0, 1, 3, 10, "R7 od");

        n0 = nrst;
        host_low(40); idle(20);
        chk(nrst == n0, "R2 od short low no reset", nrst - n0, 0);
        bits_q.delete();

        host_low(8);
        host_low(1);
        idle(10);
        chk(bits_q.size() == 2, "R8 od gap decoded", bits_q.size(), 2);
        if (bits_q.size() == 2)
            chk(bits_q[0] == 0 && bits_q[1] == 1, "R8 od bits", int'({bits_q[0], bits_q[1]}), 1);
        bits_q.delete();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule